// File: doc/BRIEF.md
# Dual-Pipe Instruction Pairing Checker

This block sits between instruction decode and two integer execution pipes: a primary pipe that accepts any instruction and a secondary pipe that accepts only simple ones. Each cycle it looks at two pre-decoded descriptors, the older one in slot 0 and the younger one in slot 1. It decides whether the older instruction issues alone into the primary pipe or whether both issue together, one into each pipe. If the pair is refused, the slot 1 instruction is expected to move into slot 0 on the following cycle. That shift is the job of the upstream queue, which watches the two issue outputs.

Pairing is granted only when all of these hold:
- the younger instruction does not depend on the older one;
- neither instruction carries a displacement or an immediate;
- both belong to the same class (floating-point or integer);
- the younger instruction is not complex.

The block also tracks occupancy of the five stages in each pipe: prefetch, decode, address generate, execute and write-back. Each pipe has a valid bit vector. A stall request from either pipe freezes both vectors in the same cycle and blocks any new issue, so the two pipes always move in lockstep.

Top module: `dual_pipe_pair_issue`

## Requirements
- R1: `issue_u_o` is high exactly when the slot 0 descriptor is valid, neither stall input is high, and the block is out of reset.
- R2: A dependency blocks pairing in any of these cases: the slot 0 destination equals the slot 1 destination; the slot 0 destination equals slot 1 source 0 and that source's use flag is set; the slot 0 destination equals slot 1 source 1 and that source's use flag is set. A matching source whose use flag is clear does not block pairing.
- R3: A displacement flag or an immediate flag set on either slot blocks pairing.
- R4: Pairing is blocked when exactly one of the two slots has the floating-point flag set. Two floating-point instructions may pair, and so may two integer instructions.
- R5: A complex flag on slot 1 blocks pairing. A complex flag on slot 0 alone does not block it.
- R6: `issue_v_o` is high exactly when `issue_u_o` is high, slot 1 is valid, and none of the conditions in R2 to R5 applies.
- R7: While either stall input is high, neither issue output is high and both stage vectors keep their values at the next clock edge.
- R8: In a cycle with no stall, each stage vector shifts up by one bit at the clock edge. Bit 0 (prefetch) takes that pipe's issue output. Bit 4 (write-back) leaves the vector on the following edge.
- R9: Asserting `rst_ni` clears both stage vectors at once, without waiting for a clock edge, and holds both issue outputs low. The block leaves reset on the second clock edge after `rst_ni` rises.
- R10: The secondary pipe's stage vector never has a bit set where the primary pipe's vector has that bit clear.
- R11: Each descriptor is 22 bits wide. Bit 21 is valid. Bits 20:16 are the destination register. Bits 15:11 are source 0 and bit 10 is its use flag. Bits 9:5 are source 1 and bit 4 is its use flag. Bit 3 is floating-point, bit 2 is complex, bit 1 is displacement and bit 0 is immediate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slot0_desc_i | input | 22 | Older instruction descriptor, layout as in R11 |
| slot1_desc_i | input | 22 | Younger instruction descriptor, layout as in R11 |
| stall_u_i | input | 1 | Stall request from the primary pipe |
| stall_v_i | input | 1 | Stall request from the secondary pipe |
| issue_u_o | output | 1 | Slot 0 issues into the primary pipe this cycle |
| issue_v_o | output | 1 | Slot 1 issues into the secondary pipe this cycle |
| u_stages_o | output | 5 | Primary pipe occupancy, bit 0 prefetch to bit 4 write-back |
| v_stages_o | output | 5 | Secondary pipe occupancy, same bit order |

## Verification
The pairing decision is driven from a table of descriptor pairs. Each entry changes one property against an independent, simple integer pair:
- a used source that matches the older destination, against the same register on a source whose use flag is clear, which separates true hazards from idle fields;
- matching destinations;
- a displacement or an immediate on either slot;
- mixed classes, against two floating-point instructions;
- a complex flag in each slot, which shows the restriction applies only to the younger slot;
- an invalid slot 0 or slot 1;
- a stall raised by each pipe in turn.

Directed sequences then follow one paired issue and one lone issue through all five stages. Each pipe's stall is held in turn in between to confirm that both vectors freeze together. A reset is applied mid-flight to show that the vectors clear asynchronously.

// File: rtl/pairchk_pkg.sv
package pairchk_pkg;
  localparam int REG_W  = 5;
  localparam int STAGES = 5;
  localparam int PIPES  = 2;

  typedef struct packed {
    logic             valid;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src0;
    logic             use0;
    logic [REG_W-1:0] src1;
    logic             use1;
    logic             is_fp;
    logic             is_cplx;
    logic             has_disp;
    logic             has_imm;
  } slot_desc_t;

  localparam int DESC_W = $bits(slot_desc_t);
endpackage

// File: rtl/pairchk_rst_sync.sv
module pairchk_rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [DEPTH-1:0] sync_q, sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[DEPTH-1];
endmodule

// File: rtl/pairchk_rules.sv
module pairchk_rules
  import pairchk_pkg::*;
(
  input  slot_desc_t older_i,
  input  slot_desc_t younger_i,
  output logic       pairable_o
);
  logic dep_hit, addr_hit, class_hit, cplx_hit;

  always_comb begin
    dep_hit   = (older_i.dst == younger_i.dst)
              | (younger_i.use0 & (younger_i.src0 == older_i.dst))
              | (younger_i.use1 & (younger_i.src1 == older_i.dst));
    addr_hit  = older_i.has_disp | older_i.has_imm
              | younger_i.has_disp | younger_i.has_imm;
    class_hit = older_i.is_fp ^ younger_i.is_fp;
    cplx_hit  = younger_i.is_cplx;
    pairable_o = younger_i.valid & ~dep_hit & ~addr_hit & ~class_hit & ~cplx_hit;
  end
endmodule

// File: rtl/pairchk_stage_track.sv
module pairchk_stage_track #(
  parameter int DEPTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             issue_i,
  output logic [DEPTH-1:0] stages_o
);
  logic [DEPTH-1:0] occ_q, occ_d;

  always_comb begin
    occ_d = occ_q;
    if (adv_i) occ_d = {occ_q[DEPTH-2:0], issue_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else         occ_q <= occ_d;
  end

  assign stages_o = occ_q;

  // R7
  track_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(stages_o));

  // R8
  track_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (stages_o == {$past(stages_o[DEPTH-2:0]), $past(issue_i)}));
endmodule

// File: rtl/dual_pipe_pair_issue.sv
module dual_pipe_pair_issue
  import pairchk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DESC_W-1:0] slot0_desc_i,
  input  logic [DESC_W-1:0] slot1_desc_i,
  input  logic              stall_u_i,
  input  logic              stall_v_i,
  output logic              issue_u_o,
  output logic              issue_v_o,
  output logic [STAGES-1:0] u_stages_o,
  output logic [STAGES-1:0] v_stages_o
);
  logic       run_n;
  slot_desc_t older, younger;
  logic       pairable, stall_any, advance;
  logic [PIPES-1:0]  issue_vec;
  logic [STAGES-1:0] occ [PIPES];

  pairchk_rst_sync #(.DEPTH(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(run_n)
  );

  assign older   = slot_desc_t'(slot0_desc_i);
  assign younger = slot_desc_t'(slot1_desc_i);

  pairchk_rules u_rules (
    .older_i(older), .younger_i(younger), .pairable_o(pairable)
  );

  always_comb begin
    stall_any = stall_u_i | stall_v_i;
    advance   = ~stall_any;
    issue_u_o = run_n & older.valid & ~stall_any;
    issue_v_o = issue_u_o & pairable;
  end

  assign issue_vec = {issue_v_o, issue_u_o};

  for (genvar p = 0; p < PIPES; p++) begin : g_pipe
    pairchk_stage_track #(.DEPTH(STAGES)) u_track (
      .clk_i(clk_i), .rst_ni(run_n), .adv_i(advance),
      .issue_i(issue_vec[p]), .stages_o(occ[p])
    );
  end

  assign u_stages_o = occ[0];
  assign v_stages_o = occ[1];

  // R10
  lockstep_subset_chk: assert property (@(posedge clk_i) disable iff (!run_n)
    (v_stages_o & ~u_stages_o) == '0);

  // R6
  v_needs_u_chk: assert property (@(posedge clk_i) disable iff (!run_n)
    issue_v_o |-> issue_u_o && younger.valid);

  // R7
  stall_blocks_issue_chk: assert property (@(posedge clk_i) disable iff (!run_n)
    (stall_u_i || stall_v_i) |-> !issue_u_o && !issue_v_o);

  // R3
  addr_mode_chk: assert property (@(posedge clk_i) disable iff (!run_n)
    issue_v_o |-> !(older.has_disp || older.has_imm || younger.has_disp || younger.has_imm));

  // R2
  dest_dep_chk: assert property (@(posedge clk_i) disable iff (!run_n)
    issue_v_o |-> older.dst != younger.dst);

  // R4
  class_match_chk: assert property (@(posedge clk_i) disable iff (!run_n)
    issue_v_o |-> older.is_fp == younger.is_fp);

  // R5
  v_simple_chk: assert property (@(posedge clk_i) disable iff (!run_n)
    issue_v_o |-> !younger.is_cplx);
endmodule

// File: tb/tb_dual_pipe_pair_issue.sv
module tb_dual_pipe_pair_issue;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [21:0] slot0_desc_i, slot1_desc_i;
  logic        stall_u_i, stall_v_i;
  logic        issue_u_o, issue_v_o;
  logic [4:0]  u_stages_o, v_stages_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  dual_pipe_pair_issue dut (.*);

  // descriptor layout (R11): valid_dst_src0_use0_src1_use1_fp.cplx.disp.imm
  localparam logic [21:0] DA  = 22'b1_00001_00010_1_00011_1_0000; // r1 <- r2,r3
  localparam logic [21:0] DB  = 22'b1_00100_00101_1_00110_1_0000; // r4 <- r5,r6
  localparam logic [21:0] IDL = 22'b0;
  localparam int NV = 17;
  // {slot0, slot1, stall_u, stall_v, exp_issue_u, exp_issue_v}
  localparam logic [47:0] VEC [NV] = '{
    {DA, DB, 2'b00, 2'b11},                              // R6 independent
    {DA, 22'b1_00100_00001_1_00110_1_0000, 2'b00, 2'b10}, // R2 src0 used
    {DA, 22'b1_00100_00101_1_00001_1_0000, 2'b00, 2'b10}, // R2 src1 used
    {DA, 22'b1_00100_00001_0_00110_1_0000, 2'b00, 2'b11}, // R2 src0 unused
    {DA, 22'b1_00001_00101_1_00110_1_0000, 2'b00, 2'b10}, // R2 same dst
    {DA | 22'h2, DB, 2'b00, 2'b10},                      // R3 disp slot0
    {DA, DB | 22'h1, 2'b00, 2'b10},                      // R3 imm slot1
    {DA | 22'h8, DB, 2'b00, 2'b10},                      // R4 fp + int
    {DA, DB | 22'h8, 2'b00, 2'b10},                      // R4 int + fp
    {DA | 22'h8, DB | 22'h8, 2'b00, 2'b11},              // R4 fp + fp
    {DA, DB | 22'h4, 2'b00, 2'b10},                      // R5 cplx slot1
    {DA | 22'h4, DB, 2'b00, 2'b11},                      // R5 cplx slot0
    {DA, IDL, 2'b00, 2'b10},                             // R6 slot1 invalid
    {IDL, DB, 2'b00, 2'b00},                             // R1 slot0 invalid
    {DA, DB, 2'b10, 2'b00},                              // R7 stall U
    {DA, DB, 2'b01, 2'b00},                              // R7 stall V
    {DA | 22'h1, DB | 22'h2, 2'b00, 2'b10}               // R3 both
  };
  localparam int VREQ [NV] = '{6, 2, 2, 2, 2, 3, 3, 4, 4, 4, 5, 5, 6, 1, 7, 7, 3};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [21:0] a, input logic [21:0] b, input logic su, input logic sv);
    slot0_desc_i = a; slot1_desc_i = b; stall_u_i = su; stall_v_i = sv;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0;
    drive(DA, DB, 1'b0, 1'b0);
    repeat (3) @(negedge clk_i);
    #2;
    check("R9 issue_u in reset", {31'b0, issue_u_o}, 0);
    check("R9 u_stages in reset", {27'b0, u_stages_o}, 0);
    check("R9 v_stages in reset", {27'b0, v_stages_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VEC[i][47:26], VEC[i][25:4], VEC[i][3], VEC[i][2]);
      #2;
      check($sformatf("R%0d vec%0d issue_u", VREQ[i], i), {31'b0, issue_u_o}, {31'b0, VEC[i][1]});
      check($sformatf("R%0d vec%0d issue_v", VREQ[i], i), {31'b0, issue_v_o}, {31'b0, VEC[i][0]});
    end

    // drain both pipes
    @(negedge clk_i); drive(IDL, IDL, 1'b0, 1'b0);
    repeat (6) @(negedge clk_i);
    #2;
    check("R8 drained u", {27'b0, u_stages_o}, 0);
    check("R8 drained v", {27'b0, v_stages_o}, 0);

    drive(DA, DB, 1'b0, 1'b0);            // paired issue
    @(negedge clk_i); drive(IDL, IDL, 1'b0, 1'b0); #2;
    check("R8 pair enters prefetch u", {27'b0, u_stages_o}, 5'b00001);
    check("R8 pair enters prefetch v", {27'b0, v_stages_o}, 5'b00001);
    @(negedge clk_i); #2;
    check("R8 shift to decode u", {27'b0, u_stages_o}, 5'b00010);
    drive(DA, DB, 1'b1, 1'b0);            // U stall
    @(negedge clk_i); #2;
    check("R7 stall_u freezes u", {27'b0, u_stages_o}, 5'b00010);
    check("R7 stall_u freezes v", {27'b0, v_stages_o}, 5'b00010);
    check("R7 stall_u no issue", {31'b0, issue_u_o}, 0);
    drive(DA, DB, 1'b0, 1'b1);            // V stall
    @(negedge clk_i); #2;
    check("R7 stall_v freezes u", {27'b0, u_stages_o}, 5'b00010);
    check("R7 stall_v freezes v", {27'b0, v_stages_o}, 5'b00010);
    drive(DA, IDL, 1'b0, 1'b0);           // lone U issue
    @(negedge clk_i); drive(IDL, IDL, 1'b0, 1'b0); #2;
    check("R8 lone issue u", {27'b0, u_stages_o}, 5'b00101);
    check("R8 lone issue v", {27'b0, v_stages_o}, 5'b00100);
    @(negedge clk_i);
    @(negedge clk_i); #2;
    check("R8 write-back u", {27'b0, u_stages_o}, 5'b10100);
    check("R10 write-back v", {27'b0, v_stages_o}, 5'b10000);
    @(negedge clk_i); #2;
    check("R8 falls out u", {27'b0, u_stages_o}, 5'b01000);
    check("R8 falls out v", {27'b0, v_stages_o}, 5'b00000);

    // mid-flight reset
    drive(DA, DB, 1'b0, 1'b0);
    @(negedge clk_i); #2;
    rst_ni = 1'b0;
    #1;
    check("R9 async clear u", {27'b0, u_stages_o}, 0);
    check("R9 async clear v", {27'b0, v_stages_o}, 0);
    check("R9 issue_v held low", {31'b0, issue_v_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); #2;
    check("R9 still in reset after one edge", {31'b0, issue_u_o}, 0);
    @(negedge clk_i); #2;
    check("R9 out of reset after two edges", {31'b0, issue_u_o}, 1);
    finish_run();
  end
endmodule